// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps an SDRAM array refreshed while the access sequencer handles reads and writes. A down-counter is loaded with the per-row refresh interval in bus clocks. Each time it runs out, the scheduler records one owed refresh. It then raises a request for the command bus and waits until the bus is granted and the sequencer reports idle. It drives a REF command for one clock and then holds its busy flag for the programmed recovery time, so that no ACTIVE can follow too soon. Software computes the interval from the per-row refresh time and the bus frequency. For example, 15625 ns per row at 60 MHz gives 937 clocks.

Auto-refresh is switched on and off by host commands, one region at a time. Self-refresh entry and exit apply to every region together. On entry the scheduler waits for the bus and issues a precharge-all. It then issues the self-refresh entry command with clock-enable low and freezes its timer. On exit it raises clock-enable, issues one REF to every region at once, and restarts periodic timing. Host command codes are 0 = enable auto-refresh, 1 = disable auto-refresh, 2 = enter self-refresh, 3 = exit self-refresh.

Top module: `rfs_sched`

## Requirements
- R1: During and after reset, `ref_req` is 0, `pin_code` is NOP (3'b111), `cke` is 1, every `cs_n` bit is 1 and `busy` is 0.
- R2: Host code 0 enables auto-refresh for the region in `host_region`, and code 1 disables it; the other regions are not affected.
- R3: With at least one region enabled and the bus always free, REFs come exactly `interval_clks` clocks apart. The first REF appears `interval_clks`+2 clocks after the clock edge that accepts the first enable.
- R4: `pin_code` is {ras_n,cas_n,we_n}: REF = 3'b001, precharge-all = 3'b010, NOP = 3'b111. A periodic REF drives `cs_n` low for exactly the regions enabled when the request was raised.
- R5: After the REF cycle, `busy` stays high for N clocks and then drops. N is 3, 6 or 9 for `recov_code` 0, 1 or 2, and 9 for code 3.
- R6: A raised `ref_req` stays high until `bus_grant` and `seq_idle` are both high at a clock edge. The command is driven in the clock that follows that edge, and never without that grant.
- R7: Intervals that expire while the bus is withheld are counted (up to 7) and each one is later served by its own REF.
- R8: Host code 2, whatever its region field, waits for grant and idle. It then issues precharge-all to all regions, and in the next clock REF with `cke` low to all regions. After that `cke` stays low with NOP.
- R9: While in self-refresh no command other than NOP is driven and the refresh timer does not advance.
- R10: Host code 3 in self-refresh raises `cke`. The REF to every region appears one clock later if the bus is free. The next periodic REF follows `interval_clks`+1 clocks after that REF.
- R11: Disabling every region stops the periodic REFs and discards owed refreshes.
- R12: An exit command outside self-refresh, and an enter command during self-refresh, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host command strobe |
| host_cmd | input | 2 | Host command code |
| host_region | input | RID_W | Region addressed by the command |
| interval_clks | input | CNT_W | Refresh interval per row, in bus clocks |
| recov_code | input | 2 | Recovery time code after REF |
| seq_idle | input | 1 | Access sequencer is idle |
| bus_grant | input | 1 | Command bus granted to this block |
| ref_req | output | 1 | Request for the command bus |
| pin_code | output | 3 | {ras_n,cas_n,we_n} command code |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | NREG | Per-region chip selects, active low |
| busy | output | 1 | Scheduler owns the bus or recovery is running; no ACTIVE allowed |

## Verification
The hardest case to reach is a backlog of refreshes owed while the bus is withheld. From the ports it only shows up as a request held high across several intervals. The stimulus holds the grant low for exactly five intervals, releases it at a computed clock, and counts the back-to-back REFs that drain the backlog. It counts them before the next expiry can add another. The self-refresh exit is also timed exactly, because the exit REF and the reloaded timer set the next periodic REF one clock later than the plain interval.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;
  typedef enum logic [1:0] {
    HC_AREF_ON  = 2'd0,
    HC_AREF_OFF = 2'd1,
    HC_SR_ENTER = 2'd2,
    HC_SR_EXIT  = 2'd3
  } host_cmd_e;

  typedef enum logic [2:0] {
    PIN_REF  = 3'b001,
    PIN_PALL = 3'b010,
    PIN_NOP  = 3'b111
  } pin_code_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_ISSUE, ST_RECOV,
    ST_SR_WAIT, ST_SR_PALL, ST_SR_ENTRY, ST_SR_HOLD
  } st_e;

  // recovery clocks after REF; code 3 behaves as code 2
  function automatic logic [3:0] recov_clks(input logic [1:0] code);
    case (code)
      2'd0:    recov_clks = 4'd3;
      2'd1:    recov_clks = 4'd6;
      default: recov_clks = 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/rfs_regions.sv
`timescale 1ns/1ps
module rfs_regions #(
  parameter int NREG  = 2,
  parameter int RID_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  input  logic [1:0]       host_cmd,
  input  logic [RID_W-1:0] host_region,
  output logic [NREG-1:0]  en_mask
);
  import rfs_pkg::*;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    assign hit = host_valid && (host_region == RID_W'(r));
    always_ff @(posedge clk) begin
      if (!rst_n)                             en_mask[r] <= 1'b0;
      else if (hit && host_cmd == HC_AREF_ON)  en_mask[r] <= 1'b1;
      else if (hit && host_cmd == HC_AREF_OFF) en_mask[r] <= 1'b0;
    end
  end
endmodule

// File: rtl/rfs_timer.sv
`timescale 1ns/1ps
module rfs_timer #(
  parameter int CNT_W = 16,
  parameter int OWE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             freeze,
  input  logic             reload,
  input  logic             consume,
  input  logic [CNT_W-1:0] interval,
  output logic             expire,
  output logic             owed_nz
);
  localparam logic [OWE_W-1:0] OWE_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [OWE_W-1:0] owed;
  logic             take;

  assign expire  = run && !freeze && !reload && (cnt <= CNT_W'(1));
  assign owed_nz = (owed != '0);
  assign take    = consume && owed_nz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      owed <= '0;
    end else begin
      if (!run || reload)  cnt <= interval;
      else if (freeze)     cnt <= cnt;
      else if (expire)     cnt <= interval;
      else                 cnt <= cnt - 1'b1;

      if (!run)                  owed <= '0;
      else if (expire && !take)  owed <= (owed == OWE_MAX) ? owed : owed + 1'b1;
      else if (!expire && take)  owed <= owed - 1'b1;
    end
  end
endmodule

// File: rtl/rfs_ctrl.sv
`timescale 1ns/1ps
module rfs_ctrl #(
  parameter int NREG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            owed_nz,
  input  logic            sr_enter,
  input  logic            sr_exit,
  input  logic            bus_grant,
  input  logic            seq_idle,
  input  logic [NREG-1:0] en_mask,
  input  logic [1:0]      recov_code,
  output logic            consume,
  output logic            freeze,
  output logic            reload,
  output logic            ref_req,
  output logic [2:0]      pin_code,
  output logic            cke,
  output logic [NREG-1:0] cs_n,
  output logic            busy
);
  import rfs_pkg::*;

  st_e             state;
  logic            sr_req;
  logic            from_exit;
  logic [NREG-1:0] tgt;
  logic [3:0]      rcnt;
  logic            won;

  assign won     = bus_grant && seq_idle;
  assign freeze  = (state == ST_SR_PALL) || (state == ST_SR_ENTRY) || (state == ST_SR_HOLD);
  assign reload  = (state == ST_SR_HOLD) && sr_exit;
  assign consume = (state == ST_ISSUE) && !from_exit;
  assign ref_req = (state == ST_REQ) || (state == ST_SR_WAIT);
  assign busy    = (state != ST_IDLE);
  assign cke     = !((state == ST_SR_ENTRY) || (state == ST_SR_HOLD));

  always_comb begin
    pin_code = PIN_NOP;
    cs_n     = '1;
    case (state)
      ST_ISSUE:    begin pin_code = PIN_REF;  cs_n = ~tgt; end
      ST_SR_PALL:  begin pin_code = PIN_PALL; cs_n = '0;   end
      ST_SR_ENTRY: begin pin_code = PIN_REF;  cs_n = '0;   end
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sr_req    <= 1'b0;
      from_exit <= 1'b0;
      tgt       <= '0;
      rcnt      <= '0;
    end else begin
      if (sr_enter && !freeze) sr_req <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (owed_nz) begin
            state     <= ST_REQ;
            tgt       <= en_mask;
            from_exit <= 1'b0;
          end else if (sr_req) begin
            state <= ST_SR_WAIT;
          end
        end
        ST_REQ:   if (won) state <= ST_ISSUE;
        ST_ISSUE: begin
          rcnt  <= recov_clks(recov_code);
          state <= ST_RECOV;
        end
        ST_RECOV: begin
          if (rcnt <= 4'd1) state <= ST_IDLE;
          else              rcnt  <= rcnt - 1'b1;
        end
        ST_SR_WAIT: if (won) begin
          state  <= ST_SR_PALL;
          sr_req <= 1'b0;
        end
        ST_SR_PALL:  state <= ST_SR_ENTRY;
        ST_SR_ENTRY: state <= ST_SR_HOLD;
        ST_SR_HOLD: if (sr_exit) begin
          state     <= ST_REQ;
          tgt       <= '1;
          from_exit <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfs_sched.sv
`timescale 1ns/1ps
module rfs_sched #(
  parameter int NREG  = 2,
  parameter int CNT_W = 16,
  parameter int OWE_W = 3,
  localparam int RID_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  input  logic [1:0]       host_cmd,
  input  logic [RID_W-1:0] host_region,
  input  logic [CNT_W-1:0] interval_clks,
  input  logic [1:0]       recov_code,
  input  logic             seq_idle,
  input  logic             bus_grant,
  output logic             ref_req,
  output logic [2:0]       pin_code,
  output logic             cke,
  output logic [NREG-1:0]  cs_n,
  output logic             busy
);
  import rfs_pkg::*;

  logic [NREG-1:0] en_mask;
  logic            any_en;
  logic            sr_enter_p;
  logic            sr_exit_p;
  logic            expire;
  logic            owed_nz;
  logic            consume;
  logic            freeze;
  logic            reload;

  assign any_en     = |en_mask;
  assign sr_enter_p = host_valid && (host_cmd == HC_SR_ENTER);
  assign sr_exit_p  = host_valid && (host_cmd == HC_SR_EXIT);

  rfs_regions #(.NREG(NREG), .RID_W(RID_W)) u_regions (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_cmd(host_cmd),
    .host_region(host_region), .en_mask(en_mask)
  );

  rfs_timer #(.CNT_W(CNT_W), .OWE_W(OWE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(any_en), .freeze(freeze), .reload(reload),
    .consume(consume), .interval(interval_clks), .expire(expire), .owed_nz(owed_nz)
  );

  rfs_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .owed_nz(owed_nz), .sr_enter(sr_enter_p),
    .sr_exit(sr_exit_p), .bus_grant(bus_grant), .seq_idle(seq_idle),
    .en_mask(en_mask), .recov_code(recov_code), .consume(consume),
    .freeze(freeze), .reload(reload), .ref_req(ref_req), .pin_code(pin_code),
    .cke(cke), .cs_n(cs_n), .busy(busy)
  );
endmodule

// File: rtl/rfs_sched_chk.sv
`timescale 1ns/1ps
module rfs_sched_chk #(
  parameter int NREG = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ref_req,
  input logic            bus_grant,
  input logic            seq_idle,
  input logic [2:0]      pin_code,
  input logic            cke,
  input logic [NREG-1:0] cs_n,
  input logic            busy,
  input logic [1:0]      recov_code,
  input logic            expire,
  input logic            freeze
);
  logic       track;
  logic [3:0] run_len;
  logic [3:0] want_len;
  logic       is_ref;

  assign is_ref = (pin_code == 3'b001) && cke;

  function automatic logic [3:0] want_of(input logic [1:0] c);
    want_of = 4'd3 * ((c == 2'd0) ? 4'd1 : (c == 2'd1) ? 4'd2 : 4'd3);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track    <= 1'b0;
      run_len  <= '0;
      want_len <= '0;
    end else if (is_ref) begin
      track    <= 1'b1;
      run_len  <= '0;
      want_len <= want_of(recov_code);
    end else if (track) begin
      if (busy) run_len <= run_len + 1'b1;
      else      track   <= 1'b0;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !(bus_grant && seq_idle) |=> ref_req); // R6
  AST_REF_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> $past(ref_req && bus_grant && seq_idle)); // R6
  AST_PALL_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_code == 3'b010) |-> $past(ref_req && bus_grant && seq_idle) && (cs_n == '0)); // R8
  AST_SR_ENTRY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(pin_code == 3'b010) && (pin_code == 3'b001) && (cs_n == '0)); // R8
  AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke && $past(!cke) |-> (pin_code == 3'b111) && !expire); // R9
  AST_FROZEN_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !expire); // R9
  AST_BUSY_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> busy); // R5
  AST_RECOV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    track && !busy |-> run_len == want_len); // R5
endmodule

bind rfs_sched rfs_sched_chk #(.NREG(NREG)) u_rfs_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .bus_grant(bus_grant),
  .seq_idle(seq_idle), .pin_code(pin_code), .cke(cke), .cs_n(cs_n),
  .busy(busy), .recov_code(recov_code), .expire(expire), .freeze(freeze)
);

// File: tb/test_rfs_sched.sv
`timescale 1ns/1ps
module test_rfs_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic [1:0]  host_cmd = 2'd0;
  logic [0:0]  host_region = 1'b0;
  logic [15:0] interval_clks = 16'd30;
  logic [1:0]  recov_code = 2'd0;
  logic        seq_idle = 1'b1;
  logic        bus_grant = 1'b1;
  logic        ref_req;
  logic [2:0]  pin_code;
  logic        cke;
  logic [1:0]  cs_n;
  logic        busy;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int pall_cnt = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && pin_code == 3'b010) pall_cnt++;

  rfs_sched i_rfs_sched (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_cmd(host_cmd),
    .host_region(host_region), .interval_clks(interval_clks),
    .recov_code(recov_code), .seq_idle(seq_idle), .bus_grant(bus_grant),
    .ref_req(ref_req), .pin_code(pin_code), .cke(cke), .cs_n(cs_n), .busy(busy)
  );

  function automatic int exp_recov(input logic [1:0] c);
    if (c == 2'd0) return 3;
    if (c == 2'd1) return 6;
    return 9;
  endfunction

  function automatic bit is_ref();
    return (pin_code == 3'b001) && cke;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic host(input logic [1:0] c, input logic r, output int edge_at);
    host_valid = 1'b1; host_cmd = c; host_region = r;
    edge_at = cyc + 1;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic wait_ref(input int lim, output int at);
    at = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (is_ref()) begin at = cyc; break; end
    end
  endtask

  task automatic busy_len(output int n);
    n = 0;
    @(negedge clk);
    while (busy && n < 40) begin n++; @(negedge clk); end
  endtask

  task automatic trial(input int iv, input logic [1:0] code, input logic [1:0] mask);
    int e0, ed, r1, r2, r3, rx, n;
    interval_clks = 16'(iv); recov_code = code;
    host(2'd0, mask[0] ? 1'b0 : 1'b1, e0);                 // R2 enable
    if (mask == 2'b11) host(2'd0, 1'b1, ed);
    wait_ref(iv + 10, r1);
    chk(r1 == e0 + iv + 2, "R3 first REF cycle", r1, e0 + iv + 2);
    chk(cs_n == ~mask, "R4 REF chip selects", cs_n, ~mask);
    busy_len(n);
    chk(n == exp_recov(code), "R5 recovery clocks", n, exp_recov(code));
    wait_ref(2 * iv, r2);
    chk(r2 - r1 == iv, "R3 REF spacing", r2 - r1, iv);
    chk(cs_n == ~mask, "R4 REF chip selects", cs_n, ~mask);
    busy_len(n);
    chk(n == exp_recov(code), "R5 recovery clocks", n, exp_recov(code));
    wait_ref(2 * iv, r3);
    chk(r3 - r2 == iv, "R3 REF spacing", r3 - r2, iv);
    if (mask[0]) host(2'd1, 1'b0, ed);
    if (mask[1]) host(2'd1, 1'b1, ed);
    wait_ref(3 * iv, rx);
    chk(rx == -1, "R11 no REF after disable", rx, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    report();
  end

  initial begin
    int e0, ed, r, x, k, n;
    logic [1:0] m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ref_req && pin_code == 3'b111 && cke && cs_n == 2'b11 && !busy,
        "R1 state in reset", {ref_req, pin_code, cke, cs_n, busy}, 8'b0_111_1_11_0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ref_req && pin_code == 3'b111 && cke && cs_n == 2'b11 && !busy,
        "R1 state after reset", {ref_req, pin_code, cke, cs_n, busy}, 8'b0_111_1_11_0);

    // directed: code 3 behaves as 9 clocks (R5), region 1 alone (R2)
    trial(20, 2'd3, 2'b10);
    // random trials
    for (int t = 0; t < 5; t++) begin
      m = 2'($urandom_range(1, 3));
      trial(24 + int'($urandom_range(0, 60)), 2'($urandom_range(0, 3)), m);
    end

    // R6: sequencer busy blocks the REF, request held
    interval_clks = 16'd30; recov_code = 2'd0; seq_idle = 1'b0;
    host(2'd0, 1'b0, e0);
    k = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ref_req) begin k = cyc; break; end
    end
    chk(k == e0 + 31, "R6 request raised", k, e0 + 31);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (is_ref() || !ref_req) n++;
    end
    chk(n == 0, "R6 request held without REF", n, 0);
    seq_idle = 1'b1; k = cyc;
    wait_ref(3, r);
    chk(r == k + 1, "R6 REF after idle", r, k + 1);
    host(2'd1, 1'b0, ed);
    repeat (40) @(negedge clk);

    // R7: five intervals owed while the grant is withheld
    interval_clks = 16'd40; recov_code = 2'd0; bus_grant = 1'b0;
    host(2'd0, 1'b1, e0);
    n = 0;
    while (cyc < e0 + 203) begin
      @(negedge clk);
      if (is_ref()) n++;
    end
    chk(n == 0, "R6 no REF without grant", n, 0);
    bus_grant = 1'b1; n = 0;
    for (int i = 0; i < 35; i++) begin
      @(negedge clk);
      if (is_ref()) n++;
    end
    chk(n == 5, "R7 owed REFs served", n, 5);
    host(2'd1, 1'b1, ed);
    wait_ref(100, r);
    chk(r == -1, "R11 owed cleared on disable", r, -1);

    // R8..R10, R12: self-refresh
    interval_clks = 16'd30; recov_code = 2'd1;
    host(2'd0, 1'b0, ed);
    host(2'd0, 1'b1, ed);
    wait_ref(40, r);
    repeat (10) @(negedge clk);
    host(2'd2, 1'b1, ed);
    k = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pin_code == 3'b010) begin k = 1; break; end
    end
    chk(k == 1 && cs_n == 2'b00, "R8 precharge-all to all regions", {k[0], cs_n}, 3'b100);
    @(negedge clk);
    chk(pin_code == 3'b001 && !cke && cs_n == 2'b00, "R8 entry code",
        {pin_code, cke, cs_n}, 6'b001_0_00);
    @(negedge clk);
    chk(pin_code == 3'b111 && !cke, "R8 held in self-refresh", {pin_code, cke}, 4'b111_0);
    host(2'd2, 1'b0, ed);                                   // R12 ignored enter
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cke || pin_code != 3'b111 || ref_req) n++;
    end
    chk(n == 0, "R9 quiet in self-refresh", n, 0);
    host(2'd3, 1'b0, x);
    wait_ref(5, r);
    chk(r == x + 1, "R10 exit REF", r, x + 1);
    chk(cs_n == 2'b00, "R10 exit REF to all regions", cs_n, 0);
    wait_ref(60, r);
    chk(r == x + 32, "R10 periodic resume", r, x + 32);
    host(2'd3, 1'b0, ed);                                   // R12 ignored exit
    wait_ref(60, r);
    chk(r == x + 62, "R12 exit outside self-refresh ignored", r, x + 62);
    chk(pall_cnt == 1, "R12 single self-refresh entry", pall_cnt, 1);
    report();
  end
endmodule